// File: doc/BRIEF.md
# Zero-Crossing Tone Discriminator for Binary FSK

This block takes a stream of 8-bit offset-binary samples of a two-tone FSK signal, one sample per clock, and turns it into a level-valued raw data bit. A comparator with a small dead band around mid-scale squares up the waveform. Every level change of that square wave, upward or downward, raises a one-clock crossing pulse.

A running count over the most recent `WIN` clocks smooths the pulses into a crossing density. That density tracks the frequency of the input. A registered comparison against `THRESH` gives the data bit: dense crossings mean the upper tone (data 1) and sparse crossings mean the lower tone (data 0).

The output has not been retimed. A bit synchronizer further down the chain samples it. The crossing pulse and the density count are also brought out to the ports.

Top module: `zc_fsk_demod`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `zc_pulse`, `density` and `data_out` are all 0, and the internal square wave is low.
- R2: The square wave goes high on a clock edge where the sample is at least `MID+HYST`, which is 132 by default. It goes low where the sample is below `MID-HYST`, which is 124 by default. A sample from 124 to 131 leaves it unchanged. `MID` is 2^(DW-1).
- R3: A rising or a falling change of the square wave makes `zc_pulse` high for exactly one clock. The pulse is seen in the clock that follows the edge capturing the sample.
- R4: `density` equals the number of `zc_pulse` cycles among the last `WIN` clocks. An isolated pulse raises it by 1 from the next edge on, for exactly `WIN` clocks.
- R5: `density` never exceeds `WIN`. With a pulse in every clock it settles at exactly `WIN`.
- R6: `data_out` is registered. After each edge it equals 1 if `density` before that edge was at least `THRESH`, and 0 otherwise.
- R7: With defaults, a steady square tone of period 8 samples gives `density` = 8 and `data_out` = 1. A tone of period 16 gives `density` = 4 and `data_out` = 0.
- R8: After the input switches between the two tones, `data_out` shows the new tone within `WIN+3` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | DW | Offset-binary ADC sample |
| zc_pulse | output | 1 | One-clock pulse per square-wave level change |
| density | output | $clog2(WIN+1) | Crossing count over the last WIN clocks |
| data_out | output | 1 | Recovered raw data level (1 = upper tone) |

## Verification
The bench builds the block with its defaults: `DW`=8, `WIN`=32, `HYST`=4 and `THRESH`=6. With these values the exact dead-band edges at 123/124 and 131/132 can be driven directly. Tones of period 8 and 16 samples fit whole numbers of crossings into the 32-clock window, so their densities are exact (8 and 4) instead of fluctuating. A two-clock alternation saturates the count at 32, and the tone-switch runs pass through densities 5 and 6 on either side of the threshold. Each decision is compared with the density seen one clock earlier.

// File: rtl/zc_fsk_demod.sv
module zc_fsk_demod #(
  parameter int DW     = 8,
  parameter int WIN    = 32,
  parameter int HYST   = 4,
  parameter int THRESH = 6,
  localparam int SW    = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample,
  output logic          zc_pulse,
  output logic [SW-1:0] density,
  output logic          data_out
);

  localparam logic [DW:0] MID   = (DW + 1)'(1) << (DW - 1);
  localparam logic [DW:0] HI_TH = MID + (DW + 1)'(HYST);
  localparam logic [DW:0] LO_TH = MID - (DW + 1)'(HYST);

  logic           sq, sq_q;
  logic [WIN-1:0] hist;
  logic           go_hi, go_lo;

  assign go_hi    = {1'b0, sample} >= HI_TH;
  assign go_lo    = {1'b0, sample} <  LO_TH;
  assign zc_pulse = sq ^ sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq   <= 1'b0;
      sq_q <= 1'b0;
    end else begin
      sq_q <= sq;
      if (go_hi)      sq <= 1'b1;
      else if (go_lo) sq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      density <= '0;
    end else begin
      hist    <= {hist[WIN-2:0], zc_pulse};
      density <= density + SW'(zc_pulse) - SW'(hist[WIN-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_out <= 1'b0;
    else        data_out <= int'(density) >= THRESH;
  end

endmodule

module zc_fsk_demod_chk #(
  parameter int DW     = 8,
  parameter int WIN    = 32,
  parameter int HYST   = 4,
  parameter int THRESH = 6,
  localparam int SW    = $clog2(WIN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] sample,
  input logic          sq,
  input logic          zc_pulse,
  input logic [SW-1:0] density,
  input logic          data_out
);

  localparam int HI_I = (1 << (DW - 1)) + HYST;
  localparam int LO_I = (1 << (DW - 1)) - HYST;

  a_r2_set_high: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sample) >= HI_I) |=> sq);

  a_r2_set_low: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sample) < LO_I) |=> !sq);

  a_r2_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sample) >= LO_I && int'(sample) < HI_I) |=> $stable(sq));

  a_r4_pulse_counted: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |=> density >= $past(density));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(density) <= WIN);

  a_r6_decision: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> data_out == (int'($past(density)) >= THRESH));

endmodule

bind zc_fsk_demod zc_fsk_demod_chk #(
  .DW(DW), .WIN(WIN), .HYST(HYST), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .sq(sq),
  .zc_pulse(zc_pulse), .density(density), .data_out(data_out)
);

// File: tb/tb_zc_fsk_demod.sv
module tb_zc_fsk_demod;
  localparam int WIN    = 32;
  localparam int THRESH = 6;
  localparam int SW     = $clog2(WIN + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    sample;
  logic          zc_pulse;
  logic [SW-1:0] density;
  logic          data_out;
  int            n_tests = 0;
  int            n_fail  = 0;

  always #2.5 clk = ~clk;

  zc_fsk_demod #(.DW(8), .WIN(WIN), .HYST(4), .THRESH(THRESH)) dut (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .zc_pulse(zc_pulse), .density(density), .data_out(data_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    sample = 8'd56;
    repeat (3) step();
    check("R1 pulse in reset", zc_pulse, 0);
    check("R1 density in reset", density, 0);
    check("R1 data in reset", data_out, 0);
    rst_n = 1'b1;
    step();
    check("R1 pulse after release", zc_pulse, 0);
    check("R1 density after release", density, 0);
  endtask

  task automatic t_slicer();
    sample = 8'd131; step();
    check("R2 131 does not set", zc_pulse, 0);
    step();
    check("R2 131 still held", zc_pulse, 0);
    sample = 8'd132; step();
    check("R3 rising crossing pulse", zc_pulse, 1);
    step();
    check("R3 rising pulse one clock", zc_pulse, 0);
    sample = 8'd124; step();
    check("R2 124 does not clear", zc_pulse, 0);
    step();
    check("R2 124 still held", zc_pulse, 0);
    sample = 8'd123; step();
    check("R3 falling crossing pulse", zc_pulse, 1);
    step();
    check("R3 falling pulse one clock", zc_pulse, 0);
    sample = 8'd56;
    repeat (WIN + 4) step();
    check("R4 window drained", density, 0);
  endtask

  task automatic t_window();
    sample = 8'd200; step();
    check("R3 isolated pulse", zc_pulse, 1);
    step();
    check("R4 pulse counted next edge", density, 1);
    repeat (WIN - 1) step();
    check("R4 pulse still counted at WIN", density, 1);
    step();
    check("R4 pulse expired after WIN", density, 0);
  endtask

  task automatic t_tone(input int period, input int exp_d, input int exp_q, input string req);
    for (int i = 0; i < 3 * WIN; i++) begin
      sample = ((i % period) < period / 2) ? 8'd56 : 8'd200;
      step();
    end
    check({req, " tone density"}, density, exp_d);
    check({req, " tone data"}, data_out, exp_q);
  endtask

  task automatic t_switch(input int period, input int exp_q);
    int prev;
    for (int i = 0; i < WIN + 3; i++) begin
      prev   = density;
      sample = ((i % period) < period / 2) ? 8'd56 : 8'd200;
      step();
      check("R6 decision follows density", data_out, (prev >= THRESH) ? 1 : 0);
    end
    check("R8 switched tone decided", data_out, exp_q);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 2 * WIN; i++) begin
      sample = i[0] ? 8'd200 : 8'd56;
      step();
    end
    check("R5 saturated density", density, WIN);
    check("R5 saturated data", data_out, 1);
  endtask

  task automatic t_midreset();
    rst_n = 1'b0;
    #1;
    check("R1 async reset density", density, 0);
    check("R1 async reset data", data_out, 0);
    check("R1 async reset pulse", zc_pulse, 0);
    step();
    rst_n = 1'b1;
    sample = 8'd56;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_slicer();
    t_window();
    t_tone(16, 4, 0, "R7 f1");
    t_tone(8, 8, 1, "R7 f2");
    t_switch(16, 0);
    t_switch(8, 1);
    t_saturate();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule